// File: doc/BRIEF.md
# SPI Pad Function Select Register

This block is a 32-bit control register that decides, pad by pad, whether a serial peripheral's pads are run by the SPI engine or left to general-purpose I/O. It covers up to eight parallel data lanes in each direction, plus the clock pad, the enable pad and eight chip-select pads. Software writes it through a simple strobe port with four byte enables. Software reads it back combinationally.

Each stored select bit steers a pad mux. When the bit is set, the pad's output and output-enable come from the SPI engine. When it is clear, they come from the GPIO logic. The value seen on every pad input goes to both consumers.

Lane 0 of each direction has a dedicated select bit in the low half of the register. The lane-0 position of the matching 8-bit lane field has no storage of its own and acts as an alias of that dedicated bit. The parameter `NUM_LANES` sets how many data lanes exist. Lane bits above that count read as zero and cannot be set.

Top module: `spi_pad_select`

## Requirements
- R1: After reset, `rd_data` is 0 and every bit of `pin_sel` is 0, so all 26 pads start in GPIO mode.
- R2: Register layout: bits 7:0 select chip-select pads 7..0; bit 8 selects the enable pad; bit 9 selects the clock pad; bit 10 selects slave-in lane 0; bit 11 selects slave-out lane 0; bits 23:16 select slave-in lanes 7..0; bits 31:24 select slave-out lanes 7..0. A 1 means the SPI engine drives the pad. A write (`wr_en` high at a clock edge) stores each byte whose `wr_be` bit is high (`wr_be[i]` covers bits 8i+7:8i), and the new value appears on `rd_data` after that edge.
- R3: A byte whose `wr_be` bit is low keeps its stored value across a write.
- R4: Bit 24 has no storage of its own. A write with `wr_be[3]` high and `wr_be[1]` low stores `wr_data[24]` into bit 11. `rd_data[24]` always equals `rd_data[11]`.
- R5: Bit 16 has no storage of its own. A write with `wr_be[2]` high and `wr_be[1]` low stores `wr_data[16]` into bit 10. `rd_data[16]` always equals `rd_data[10]`.
- R6: When one write enables both byte 1 and the alias's byte, bit 11 takes `wr_data[11]` and bit 10 takes `wr_data[10]`. The alias bits 24 and 16 are ignored in that case.
- R7: Bits 15:12 always read 0, and writes to them have no effect.
- R8: Lanes numbered `NUM_LANES` and above, in both lane fields, always read 0 and cannot be written. Their pads stay in GPIO mode.
- R9: `pin_sel` is indexed as follows: pins 7:0 are the chip selects, pin 8 is enable, pin 9 is clock, pins 17:10 are slave-in lanes 0..7, and pins 25:18 are slave-out lanes 0..7. `pin_sel` equals `{rd_data[31:16], rd_data[9:0]}`.
- R10: For each pin p, `pad_out[p]`/`pad_oe[p]` equal `spi_out[p]`/`spi_oe[p]` when `pin_sel[p]` is 1, and `gpio_out[p]`/`gpio_oe[p]` otherwise. This holds in the same cycle, with no register in the path.
- R11: `spi_in` and `gpio_in` both equal `pad_in` combinationally, whatever the select bits hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Single-cycle write strobe |
| wr_be | input | 4 | Byte enables for the write |
| wr_data | input | 32 | Write data |
| rd_data | output | 32 | Combinational register read value |
| pin_sel | output | 26 | Per-pin function select, 1 = SPI |
| spi_out | input | 26 | SPI engine pad output values |
| spi_oe | input | 26 | SPI engine pad output enables |
| gpio_out | input | 26 | GPIO pad output values |
| gpio_oe | input | 26 | GPIO pad output enables |
| pad_out | output | 26 | Muxed pad output values |
| pad_oe | output | 26 | Muxed pad output enables |
| pad_in | input | 26 | Values seen at the pads |
| spi_in | output | 26 | Pad inputs routed to the SPI engine |
| gpio_in | output | 26 | Pad inputs routed to the GPIO logic |

## Verification
The bench is built with five lanes so that lane masking is visible. It writes an all-ones value with every byte enabled, which shows at once whether the reserved bits and the lanes above the count are dropped.

It then runs single-byte writes on the alias bytes, which exercise the alias paths. Writes that enable byte 1 together with byte 2 or byte 3, carrying conflicting alias and dedicated values, show which source wins. A write with all enables low, and random writes with random enables, show byte masking.

On every clock the pad sources are drawn at random, so each pad mux is seen in both settings with differing SPI and GPIO values.

// File: rtl/spi_pad_select.sv
module spi_pad_select #(
  parameter int NUM_LANES = 8
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic [3:0]  wr_be,
  input  logic [31:0] wr_data,
  output logic [31:0] rd_data,
  output logic [25:0] pin_sel,
  input  logic [25:0] spi_out,
  input  logic [25:0] spi_oe,
  input  logic [25:0] gpio_out,
  input  logic [25:0] gpio_oe,
  output logic [25:0] pad_out,
  output logic [25:0] pad_oe,
  input  logic [25:0] pad_in,
  output logic [25:0] spi_in,
  output logic [25:0] gpio_in
);
  localparam logic [7:0] LANE_MASK = 8'((1 << NUM_LANES) - 1);

  logic [7:0] cs_q, dout_q, din_q;
  logic       ena_q, sck_q;
  logic       dout0_nxt, din0_nxt;

  assign dout0_nxt = wr_be[1] ? wr_data[11] : wr_data[24];
  assign din0_nxt  = wr_be[1] ? wr_data[10] : wr_data[16];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cs_q   <= '0;
      dout_q <= '0;
      din_q  <= '0;
      ena_q  <= 1'b0;
      sck_q  <= 1'b0;
    end else if (wr_en) begin
      if (wr_be[0]) cs_q <= wr_data[7:0];
      if (wr_be[1]) begin
        ena_q <= wr_data[8];
        sck_q <= wr_data[9];
      end
      if (wr_be[3]) dout_q[7:1] <= wr_data[31:25] & LANE_MASK[7:1];
      if (wr_be[2]) din_q[7:1]  <= wr_data[23:17] & LANE_MASK[7:1];
      if (wr_be[1] || wr_be[3]) dout_q[0] <= dout0_nxt;
      if (wr_be[1] || wr_be[2]) din_q[0]  <= din0_nxt;
    end
  end

  assign rd_data = {dout_q & LANE_MASK, din_q & LANE_MASK, 4'b0000,
                    dout_q[0], din_q[0], sck_q, ena_q, cs_q};

  assign pin_sel = {dout_q & LANE_MASK, din_q & LANE_MASK, sck_q, ena_q, cs_q};

  for (genvar p = 0; p < 26; p++) begin : g_pad
    assign pad_out[p] = pin_sel[p] ? spi_out[p] : gpio_out[p];
    assign pad_oe[p]  = pin_sel[p] ? spi_oe[p]  : gpio_oe[p];
  end

  assign spi_in  = pad_in;
  assign gpio_in = pad_in;
endmodule

module spi_pad_select_chk #(
  parameter int NUM_LANES = 8
) (
  input logic        clk,
  input logic        rst_n,
  input logic        wr_en,
  input logic [3:0]  wr_be,
  input logic [31:0] wr_data,
  input logic [31:0] rd_data,
  input logic [25:0] pin_sel,
  input logic [25:0] pad_out,
  input logic [25:0] spi_out,
  input logic [25:0] gpio_out
);
  localparam logic [7:0] HI_MASK = ~8'((1 << NUM_LANES) - 1);

  // R4
  alias_dout_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_data[24] == rd_data[11]);

  // R5
  alias_din_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_data[16] == rd_data[10]);

  // R7
  reserved_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_data[15:12] == 4'b0000);

  // R8
  lane_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((rd_data[31:24] | rd_data[23:16]) & HI_MASK) == 8'h00);

  // R3
  byte_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !wr_be[0]) |=> $stable(rd_data[7:0]));

  // R6
  dedicated_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_be[1] && wr_be[3]) |=> rd_data[11] == $past(wr_data[11]));

  // R9
  sel_matches_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pin_sel == {rd_data[31:16], rd_data[9:0]});

  // R10
  pad_mux_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((pad_out ^ spi_out) & pin_sel) == 26'd0);
endmodule

bind spi_pad_select spi_pad_select_chk #(.NUM_LANES(NUM_LANES)) u_chk (.*);

// File: tb/test_spi_pad_select.sv
module test_spi_pad_select;
  localparam int LANES = 5;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [3:0]  wr_be = '0;
  logic [31:0] wr_data = '0;
  logic [31:0] rd_data;
  logic [25:0] pin_sel, pad_out, pad_oe, spi_in, gpio_in;
  logic [25:0] spi_out = '0, spi_oe = '0, gpio_out = '0, gpio_oe = '0, pad_in = '0;

  int tests = 0;
  int fails = 0;
  logic [31:0] model;
  bit done = 1'b0;

  always #10 clk = ~clk;

  spi_pad_select #(.NUM_LANES(LANES)) i_spi_pad_select (.*);

  function automatic logic [31:0] apply(logic [31:0] cur, logic [31:0] d, logic [3:0] be);
    logic [31:0] n = cur;
    for (int b = 0; b < 4; b++)
      if (be[b]) n[8*b +: 8] = d[8*b +: 8];
    if (be[3] && !be[1]) n[11] = d[24];
    if (be[2] && !be[1]) n[10] = d[16];
    n[24] = n[11];
    n[16] = n[10];
    n[15:12] = 4'b0000;
    for (int k = LANES; k < 8; k++) begin
      n[24+k] = 1'b0;
      n[16+k] = 1'b0;
    end
    return n;
  endfunction

  always @(posedge clk)
    if (!rst_n) model <= '0;
    else if (wr_en) model <= apply(model, wr_data, wr_be);

  task automatic check(bit ok, string req, logic [31:0] act, logic [31:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  always @(negedge clk) if (rst_n && !done) begin
    logic [25:0] sel_e;
    sel_e = {model[31:16], model[9:0]};
    check(rd_data == model, "R2 read vs model", rd_data, model);
    check(pin_sel == sel_e, "R9 pin_sel", 32'(pin_sel), 32'(sel_e));
    check(pad_out == ((sel_e & spi_out) | (~sel_e & gpio_out)), "R10 pad_out",
          32'(pad_out), 32'((sel_e & spi_out) | (~sel_e & gpio_out)));
    check(pad_oe == ((sel_e & spi_oe) | (~sel_e & gpio_oe)), "R10 pad_oe",
          32'(pad_oe), 32'((sel_e & spi_oe) | (~sel_e & gpio_oe)));
    check(spi_in == pad_in && gpio_in == pad_in, "R11 input fanout",
          32'(spi_in ^ gpio_in), 32'(pad_in));
    spi_out  = 26'($urandom);
    spi_oe   = 26'($urandom);
    gpio_out = 26'($urandom);
    gpio_oe  = 26'($urandom);
    pad_in   = 26'($urandom);
  end

  task automatic wr(logic [31:0] d, logic [3:0] be);
    @(negedge clk);
    wr_en = 1'b1; wr_data = d; wr_be = be;
    @(negedge clk);
    wr_en = 1'b0; wr_data = '0; wr_be = '0;
  endtask

  initial begin
    #100000000;
    fails++;
    $display("FAIL watchdog expired actual=%h expected=%h", 32'd0, 32'd1);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check(rd_data == 32'd0 && pin_sel == 26'd0, "R1 reset state", rd_data, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check(pad_out == gpio_out, "R1 pads in GPIO after reset", 32'(pad_out), 32'(gpio_out));

    wr(32'hFFFF_FFFF, 4'b1111);
    check(rd_data == 32'h1F1F_0FFF, "R2 R7 R8 all-ones write", rd_data, 32'h1F1F_0FFF);
    check(pin_sel[25:23] == 3'b000 && pin_sel[17:15] == 3'b000,
          "R8 unimplemented lanes stay GPIO", 32'(pin_sel), 32'h0);

    wr(32'hFFFF_FFFF, 4'b0000);
    check(rd_data == 32'h1F1F_0FFF, "R3 no enables no change", rd_data, 32'h1F1F_0FFF);

    wr(32'h0000_0000, 4'b1000);
    check(rd_data == 32'h001F_07FF, "R4 alias 24 clears bit 11", rd_data, 32'h001F_07FF);

    wr(32'h0000_0000, 4'b0100);
    check(rd_data == 32'h0000_03FF, "R5 alias 16 clears bit 10", rd_data, 32'h0000_03FF);

    wr(32'h0100_0000, 4'b1010);
    check(rd_data == 32'h0000_00FF, "R6 bit 11 beats bit 24", rd_data, 32'h0000_00FF);

    wr(32'h0000_0400, 4'b0110);
    check(rd_data[10] == 1'b1 && rd_data[16] == 1'b1, "R6 bit 10 beats bit 16",
          rd_data, 32'h0001_04FF);

    wr(32'h0000_0800, 4'b0010);
    check(rd_data[24] == 1'b1 && pin_sel[18] == 1'b1, "R4 read of 24 follows 11",
          rd_data, 32'h0100_08FF);

    wr(32'h0001_0000, 4'b0100);
    check(rd_data[10] == 1'b1 && rd_data[23:17] == 7'd0, "R5 alias set via 16",
          rd_data, model);

    wr(32'h0000_F000, 4'b0010);
    check(rd_data[15:12] == 4'h0, "R7 reserved write ignored", rd_data, model);

    wr(32'hE0E0_0000, 4'b1100);
    check(rd_data[31:29] == 3'd0 && rd_data[23:21] == 3'd0, "R8 high lanes not writable",
          rd_data, model);

    for (int i = 0; i < 300; i++) wr($urandom, 4'($urandom));
    check(rd_data == model, "R3 random byte-enable writes", rd_data, model);

    repeat (2) @(negedge clk);
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule